// File: doc/BRIEF.md
# Output Clock Divider with Stepped Power-Down

This block takes a fast clock and produces an output clock at one of four programmed ratios (1, 2, 4 or 8), with a 50% duty cycle at each ratio. For ratio 1 the output follows the fast clock. For the other ratios a counter builds the output, and it switches ratio only when a new output period begins.

A power-down request does not stop the output. It raises the extra division one doubling at a time until the output runs 16 times slower than programmed. A separate, slower reference clock paces these steps, so each step lasts a fixed number of reference cycles. When the request is removed, the output falls back to the programmed rate through four doublings in the other direction. If the request changes in the middle of a walk, the walk turns around at the current stage. It does not restart.

The step index is kept in the reference clock domain. It crosses into the fast domain as a Gray-coded value. A status flag shows when the output runs at its programmed rate with no step still pending.

Top module: `odiv_top`

## Requirements
- R1: With power-down low and settled, ratio codes 0, 1, 2 and 3 give an output period of 1, 2, 4 and 8 fast-clock cycles.
- R2: Every output high phase lasts exactly half of its own period. This holds for ratio 1, where the output follows the fast clock, and for every stepped period.
- R3: When power-down is held and the walk is complete, the output period is 16 times the programmed ratio. With code 3 this is 128 fast cycles.
- R4: Two successive changes of the extra division are STEP_CYCLES reference cycles apart. A full four-step walk therefore takes at least 4 x STEP_CYCLES reference periods after the request changes. The Gray-coded step index changes by at most one bit per reference cycle.
- R5: When power-down is released, the distinct output periods observed run 16x, 8x, 4x, 2x, 1x the programmed ratio, in that order.
- R6: When power-down is asserted, the distinct output periods observed run 1x, 2x, 4x, 8x, 16x the programmed ratio, in that order.
- R7: A new ratio code or a new step takes effect only at the rising edge that starts an output period, so no shortened pulse appears.
- R8: at_rate is high only when the applied extra division is 1 and the synchronised step index is 0. It is low while a power-down walk is in progress or complete.
- R9: If power-down is released after two steps up, the output returns to the programmed rate through 4x, 2x, 1x. It never reaches 8x.
- R10: While rst_n is low, at_rate is low. After release with power-down low, the output runs directly at the programmed ratio, with no step sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock to be divided |
| clk_ref | input | 1 | Reference clock that paces the power-down steps |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ratio_code | input | CODE_W | Ratio code; the programmed ratio is 2 to the power of the code |
| pwr_down | input | 1 | Power-down request (asynchronous) |
| clk_out | output | 1 | Divided output clock |
| at_rate | output | 1 | High when the output runs at the programmed rate |

## Verification
A ratio change is applied at the next output period start. The bench sees it one full period later, when the next rising edge closes the period being measured. A step in the extra division reaches the output a few cycles after it happens: two reference flops carry the request in, the step is registered in the reference domain, two fast flops carry it across, and then the output waits for the current period to end. The bench does not predict an exact cycle for these effects. It polls, on falling fast-clock edges and with a bounded timeout, for the measured period it expects. It then compares the ordered log of distinct periods and their timestamps with the required sequence and the minimum pacing. A monitor compares high phase with period on every output period for the whole run.

// File: rtl/odiv_pkg.sv
`timescale 1ns/1ps
package odiv_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } odiv_dir_e;
endpackage

// File: rtl/odiv_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchroniser; the input must change at most one bit at a time.
module odiv_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/odiv_pace.sv
`timescale 1ns/1ps
// Reference-domain step sequencer: walks the step index toward 0 or STEPS.
module odiv_pace
    import odiv_pkg::*;
#(
    parameter int STEPS       = 4,
    parameter int STEP_CYCLES = 16,
    parameter int STEP_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_s,
    output logic [STEP_W-1:0] gray_o
);
    localparam int TMR_W = $clog2(STEP_CYCLES + 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic [TMR_W-1:0]  tmr;
        logic [STEP_W-1:0] gray;
    } pace_st_t;

    pace_st_t  s_d, s_q;
    odiv_dir_e dir;
    logic [STEP_W-1:0] tgt;

    always_comb begin
        s_d = s_q;
        tgt = pd_s ? STEP_W'(STEPS) : '0;
        if (s_q.step < tgt) begin
            dir = DIR_UP;
        end else if (s_q.step > tgt) begin
            dir = DIR_DOWN;
        end else begin
            dir = DIR_HOLD;
        end

        if (dir == DIR_HOLD) begin
            s_d.tmr = '0;
        end else if (s_q.tmr == TMR_W'(STEP_CYCLES - 1)) begin
            s_d.tmr  = '0;
            s_d.step = (dir == DIR_UP) ? s_q.step + 1'b1 : s_q.step - 1'b1;
        end else begin
            s_d.tmr = s_q.tmr + 1'b1;
        end
        s_d.gray = s_d.step ^ (s_d.step >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gray_o = s_q.gray;
endmodule

// File: rtl/odiv_core.sv
`timescale 1ns/1ps
// Fast-domain counter divider; loads a new exponent only at an output period start.
module odiv_core #(
    parameter int CODE_W = 2,
    parameter int STEP_W = 3,
    parameter int EXP_W  = 3,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic [STEP_W-1:0] step_s,
    output logic              div_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              ready_o
);
    localparam int PW = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              div;
        logic [EXP_W-1:0]  expn;
        logic [STEP_W-1:0] step;
        logic              ready;
    } core_st_t;

    core_st_t s_d, s_q;
    logic [PW-1:0]    per, half, nxt;
    logic             last;
    logic [EXP_W-1:0] exp_tgt;

    always_comb begin
        s_d     = s_q;
        per     = PW'(1) << s_q.expn;
        half    = per >> 1;
        nxt     = {1'b0, s_q.cnt} + PW'(1);
        last    = (s_q.expn == '0) || (nxt == per);
        exp_tgt = EXP_W'(code) + EXP_W'(step_s);
        if (last) begin
            s_d.cnt  = '0;
            s_d.div  = 1'b1;
            s_d.expn = exp_tgt;
            s_d.step = step_s;
        end else begin
            s_d.cnt = nxt[CNT_W-1:0];
            s_d.div = (nxt < half);
        end
        s_d.ready = (s_d.step == '0) && (step_s == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= '0;
            s_q.div   <= 1'b1;
            s_q.expn  <= '0;
            s_q.step  <= '0;
            s_q.ready <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign div_o   = s_q.div;
    assign exp_o   = s_q.expn;
    assign ready_o = s_q.ready;
endmodule

// File: rtl/odiv_top.sv
`timescale 1ns/1ps
module odiv_top #(
    parameter int CODE_W      = 2,
    parameter int STEPS       = 4,
    parameter int STEP_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_fast,
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              pwr_down,
    output logic              clk_out,
    output logic              at_rate
);
    localparam int STEP_W  = $clog2(STEPS + 1);
    localparam int MAX_EXP = (1 << CODE_W) - 1 + STEPS;
    localparam int CNT_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;
    localparam int EXP_W   = $clog2(MAX_EXP + 1);

    logic              pd_s;
    logic [STEP_W-1:0] gray_r, gray_f, step_s;
    logic              div_w;
    logic [EXP_W-1:0]  exp_w;

    function automatic logic [STEP_W-1:0] gray2bin(input logic [STEP_W-1:0] g);
        logic [STEP_W-1:0] b;
        b[STEP_W-1] = g[STEP_W-1];
        for (int i = STEP_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    odiv_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pd_sync (
        .clk(clk_ref), .rst_n(rst_n), .d(pwr_down), .q(pd_s)
    );

    odiv_pace #(.STEPS(STEPS), .STEP_CYCLES(STEP_CYCLES), .STEP_W(STEP_W)) u_pace (
        .clk(clk_ref), .rst_n(rst_n), .pd_s(pd_s), .gray_o(gray_r)
    );

    odiv_sync #(.W(STEP_W), .STAGES(SYNC_STAGES)) u_step_sync (
        .clk(clk_fast), .rst_n(rst_n), .d(gray_r), .q(gray_f)
    );

    assign step_s = gray2bin(gray_f);

    odiv_core #(.CODE_W(CODE_W), .STEP_W(STEP_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_core (
        .clk(clk_fast), .rst_n(rst_n), .code(ratio_code), .step_s(step_s),
        .div_o(div_w), .exp_o(exp_w), .ready_o(at_rate)
    );

    assign clk_out = (exp_w == '0) ? clk_fast : div_w;
endmodule

// File: rtl/odiv_chk.sv
`timescale 1ns/1ps
module odiv_chk #(
    parameter int EXP_W  = 3,
    parameter int STEP_W = 3,
    parameter int STEPS  = 4
) (
    input logic              clk_fast,
    input logic              clk_ref,
    input logic              rst_n,
    input logic [EXP_W-1:0]  exp_w,
    input logic              div_w,
    input logic              at_rate,
    input logic [STEP_W-1:0] step_s,
    input logic [STEP_W-1:0] gray_r
);
    // R7: a new exponent appears only together with the high phase of a new period
    a_r7_switch_at_rise: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(exp_w) |-> div_w);

    // R8: status high implies the step seen last cycle was zero
    a_r8_ready_base: assert property (@(posedge clk_fast) disable iff (!rst_n)
        at_rate |-> ($past(step_s) == '0));

    // R5: the synchronised step moves by at most one per fast cycle
    a_r5_single_step: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$stable(step_s) |-> ((step_s == $past(step_s) + 1'b1) || (step_s + 1'b1 == $past(step_s))));

    // R3: step index never exceeds the full power-down depth
    a_r3_step_bound: assert property (@(posedge clk_fast) disable iff (!rst_n)
        step_s <= STEP_W'(STEPS));

    // R4: the Gray code changes at most one bit per reference cycle
    a_r4_gray_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $onehot0(gray_r ^ $past(gray_r)));
endmodule

bind odiv_top odiv_chk #(.EXP_W(EXP_W), .STEP_W(STEP_W), .STEPS(STEPS)) u_chk (
    .clk_fast(clk_fast), .clk_ref(clk_ref), .rst_n(rst_n), .exp_w(exp_w),
    .div_w(div_w), .at_rate(at_rate), .step_s(step_s), .gray_r(gray_r)
);

// File: tb/odiv_top_test.sv
`timescale 1ns/1ps
module odiv_top_test;
    localparam int     STEP_CYCLES = 16;
    localparam longint REF_NS      = 20;
    localparam longint WALK_NS     = 4 * STEP_CYCLES * REF_NS;
    localparam int     VEC_N       = 4;
    // upper byte: ratio code, lower byte: expected period in ns
    localparam logic [15:0] VEC [VEC_N] = '{16'h0004, 16'h0108, 16'h0210, 16'h0320};

    logic       clk_fast = 1'b0;
    logic       clk_ref  = 1'b0;
    logic       rst_n    = 1'b0;
    logic [1:0] ratio_code = 2'd0;
    logic       pwr_down = 1'b0;
    logic       clk_out;
    logic       at_rate;

    int n_chk = 0;
    int n_bad = 0;

    always #2  clk_fast = ~clk_fast;
    always #10 clk_ref  = ~clk_ref;

    odiv_top #(.STEP_CYCLES(STEP_CYCLES)) uut (
        .clk_fast(clk_fast), .clk_ref(clk_ref), .rst_n(rst_n),
        .ratio_code(ratio_code), .pwr_down(pwr_down),
        .clk_out(clk_out), .at_rate(at_rate)
    );

    // output period monitor
    longint t_rise = 0;
    bit     have_rise = 1'b0;
    longint per_ns = 0;
    longint hi_ns = 0;
    int     duty_bad = 0;
    bit     mon_en = 1'b0;
    bit     log_en = 1'b0;
    int     log_n = 0;
    longint log_v [16];
    longint log_t [16];
    longint last_log = 0;

    always @(posedge clk_out) begin
        if (have_rise) begin
            per_ns = $time - t_rise;
            if (mon_en && (hi_ns * 2 != per_ns)) duty_bad++;
            if (log_en && per_ns != last_log && log_n < 16) begin
                log_v[log_n] = per_ns;
                log_t[log_n] = $time;
                log_n++;
                last_log = per_ns;
            end
        end
        t_rise = $time;
        have_rise = 1'b1;
    end

    always @(negedge clk_out) hi_ns = $time - t_rise;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_per(input longint target, input int max_cyc);
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge clk_fast);
            if (per_ns == target) return;
        end
    endtask

    task automatic wait_ready(input int max_cyc);
        for (int i = 0; i < max_cyc; i++) begin
            @(negedge clk_fast);
            if (at_rate) return;
        end
    endtask

    task automatic start_log();
        log_n = 0;
        last_log = 0;
        log_en = 1'b1;
    endtask

    task automatic chk_log(input string req, input longint e0, input longint e1,
                           input longint e2, input longint e3, input longint e4);
        longint ex [5];
        ex = '{e0, e1, e2, e3, e4};
        chk({req, " step count"}, log_n, 5);
        for (int i = 0; i < 5; i++) begin
            chk({req, " step period"}, log_v[i], ex[i]);
        end
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint t0;
        // R10: reset state
        repeat (10) @(negedge clk_fast);
        chk("R10 at_rate in reset", at_rate, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk_fast);
        chk("R8 at_rate after reset", at_rate, 1);
        mon_en = 1'b1;

        // R1, R2: static ratios from the vector table
        for (int v = 0; v < VEC_N; v++) begin
            ratio_code = VEC[v][9:8];
            repeat (40) @(negedge clk_fast);
            chk("R1 period", per_ns, longint'(VEC[v][7:0]));
            chk("R2 high phase", hi_ns * 2, longint'(VEC[v][7:0]));
        end

        // R6, R3, R4, R8: power-down walk with code 1
        ratio_code = 2'd1;
        repeat (40) @(negedge clk_fast);
        start_log();
        t0 = $time;
        pwr_down = 1'b1;
        wait_per(128, 2000);
        repeat (100) @(negedge clk_fast);
        log_en = 1'b0;
        chk_log("R6", 8, 16, 32, 64, 128);
        chk("R3 period at 16x", per_ns, 128);
        chk("R4 walk-down pacing", ((log_t[4] - t0) >= WALK_NS) ? 1 : 0, 1);
        chk("R8 at_rate while powered down", at_rate, 0);

        // R5, R4, R8: return walk
        start_log();
        t0 = $time;
        pwr_down = 1'b0;
        wait_per(8, 2000);
        wait_ready(200);
        repeat (100) @(negedge clk_fast);
        log_en = 1'b0;
        chk_log("R5", 128, 64, 32, 16, 8);
        chk("R4 walk-up pacing", ((log_t[4] - t0) >= WALK_NS) ? 1 : 0, 1);
        chk("R8 at_rate restored", at_rate, 1);

        // R9: reversal after two steps up
        start_log();
        pwr_down = 1'b1;
        wait_per(32, 2000);
        chk("R8 at_rate mid-walk", at_rate, 0);
        pwr_down = 1'b0;
        wait_per(8, 2000);
        wait_ready(200);
        repeat (100) @(negedge clk_fast);
        log_en = 1'b0;
        chk_log("R9", 8, 16, 32, 16, 8);

        // R3 at the largest code, R1 on return
        ratio_code = 2'd3;
        repeat (40) @(negedge clk_fast);
        pwr_down = 1'b1;
        wait_per(512, 4000);
        repeat (300) @(negedge clk_fast);
        chk("R3 period at 16x code 3", per_ns, 512);
        pwr_down = 1'b0;
        wait_per(32, 4000);
        wait_ready(200);
        repeat (40) @(negedge clk_fast);
        chk("R1 period after return code 3", per_ns, 32);

        // R2, R7: every observed period had a half-length high phase
        chk("R2 R7 duty violations", duty_bad, 0);

        // R10: reset in the middle of power-down returns straight to the ratio
        ratio_code = 2'd1;
        pwr_down = 1'b1;
        wait_per(64, 3000);
        mon_en = 1'b0;
        @(negedge clk_fast);
        rst_n = 1'b0;
        pwr_down = 1'b0;
        repeat (5) @(negedge clk_fast);
        chk("R10 at_rate in mid-walk reset", at_rate, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk_fast);
        chk("R10 period after reset", per_ns, 8);
        chk("R10 at_rate after reset", at_rate, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule